// File: doc/BRIEF.md
# Split Extended-Precision Signed Adder

This block forms a 52-bit two's-complement sum of a signed 18x18 product and one or two wide signed operands. The work is split at a fixed boundary. A 44-bit lower adder adds the product to the low bits of the wide operands and produces a carry-out. A narrow upper adder then adds the high bits of the operands to a small correction vector. The correction vector is built from that carry-out, from the product's sign and, when three terms are added, from the top bit of the lower sum. The result is exact modulo 2^52 for every input pattern.

A per-operation mode input picks one of two forms. The two-term form adds wide operand C to the product and delivers its result on the edge that samples the inputs. The three-term form adds C, D and the product. It runs through a two-stage pipeline and delivers its result two edges after the sampling edge. An operation can be presented on every cycle, and the mode may change from one operation to the next. When a three-term result and a two-term result fall due on the same edge, the older three-term result has priority.

Top module: `ext_sum52`

## Requirements
- R1: While `rst_n` is low at a rising edge, `sum_q` becomes 0 and every three-term operation already in flight is discarded. None of them appears after reset is released.
- R2: With `three_in` = 0 (two-term form), the edge that samples the operands loads `sum_q` with (C + sign-extended signed(A)×signed(B)) mod 2^52. This holds unless a three-term result is due on that edge (R5). A and B are 18-bit two's-complement values and C is a 52-bit two's-complement value.
- R3: With `three_in` = 1 (three-term form), `sum_q` holds (C + D + sign-extended signed(A)×signed(B)) mod 2^52 after the second rising edge that follows the sampling edge. That is the third edge counting the sampling edge.
- R4: The result stays exact when the lower field carries out of, or borrows across, the split point: bit 44 in the two-term form and bit 43 in the three-term form. This includes the most negative product (-2^17 × (2^17-1)), the largest product (2^34), and operands at or near +2^51-1 and -2^51.
- R5: A three-term result is written on its due edge even when a two-term operation is sampled on that same edge. That two-term operation's result never appears on `sum_q`.
- R6: When a three-term operation is sampled on an edge and no three-term result is due on that edge, `sum_q` keeps its previous value.
- R7: In the two-term form, the value on D has no effect on the result.
- R8: The mode is taken per operation together with its operands. Switching the mode between consecutive operations does not change the value of any result already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 18 | Signed multiplier operand |
| op_b | input | 18 | Signed multiplier operand |
| op_c | input | 52 | Signed wide addend, used in both forms |
| op_d | input | 52 | Signed wide addend, used only in the three-term form |
| three_in | input | 1 | Form select: 0 adds two terms, 1 adds three terms |
| sum_q | output | 52 | Registered 52-bit signed result |

## Verification
A two-term result is due on `sum_q` right after the edge that samples its operands. A three-term result is due two edges later. The bench drives one operation on each falling edge. On the following falling edge it compares `sum_q` against a model that keeps the last three operations. That model applies the due-edge rule: a three-term operation sampled two edges earlier wins, otherwise the current two-term operation is shown, otherwise the value holds. So every cycle is checked, including the edges where the mode changes. Expected sums are formed with plain 52-bit arithmetic, with no split at bit 44 or bit 43.

// File: rtl/ext_sum52_pkg.sv
// Shared widths and the form encoding for the split extended-precision adder.
package ext_sum52_pkg;
    localparam int DEF_MUL_W = 18;   // multiplier operand width
    localparam int DEF_LOW_W = 44;   // width of the lower adder
    localparam int DEF_RES_W = 52;   // width of the full result

    typedef enum logic {
        FORM_TWO   = 1'b0,
        FORM_THREE = 1'b1
    } add_form_e;
endpackage

// File: rtl/ext_sum52_mul.sv
// Signed multiplier feeding the lower adder.
// Produces the product sign-extended to the lower adder width and the product sign.
// Assumes LW is strictly wider than the 2*AW product.
module ext_sum52_mul #(
    parameter int AW = 18,
    parameter int LW = 44
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    output logic [LW-1:0] prod_ext,
    output logic          prod_neg
);
    localparam int PW = 2 * AW;

    logic signed [PW-1:0] prod;

    // full-width signed product
    assign prod     = $signed(a) * $signed(b);
    // sign-extend to the lower adder width
    assign prod_ext = {{(LW - PW){prod[PW-1]}}, prod};
    assign prod_neg = prod[PW-1];
endmodule

// File: rtl/ext_sum52_low.sv
// Lower adder: sums three LW-bit unsigned fields and reports the carry out of bit LW-1.
// Assumes that the callers keep the true sum below 2^(LW+1), so one carry bit suffices.
module ext_sum52_low #(
    parameter int LW = 44
) (
    input  logic [LW-1:0] x,
    input  logic [LW-1:0] y,
    input  logic [LW-1:0] z,
    output logic [LW-1:0] sum,
    output logic          cout
);
    logic [LW:0] full;

    // three-operand add, one guard bit
    assign full = {1'b0, x} + {1'b0, y} + {1'b0, z};
    assign sum  = full[LW-1:0];
    assign cout = full[LW];
endmodule

// File: rtl/ext_sum52_up.sv
// Upper adder: adds the high operand fields to a correction vector.
// The correction vector accounts for the lower carry-out and for the product's
// sign extension above the split. When LB = 2 the lower sum's top bit rides in
// the correction LSB, under the carry position.
// Assumes UW > LB and that lo_bits = {carry, lower-field bits below it}.
module ext_sum52_up #(
    parameter int UW = 8,
    parameter int LB = 1
) (
    input  logic [UW-1:0] hi_c,
    input  logic [UW-1:0] hi_d,
    input  logic [LB-1:0] lo_bits,
    input  logic          prod_neg,
    output logic [UW-1:0] sum
);
    logic          cy;
    logic          fill;
    logic [UW-1:0] corr;

    assign cy   = lo_bits[LB-1];
    // carry minus product sign, in the carry's weight: fill is set only for -1
    assign fill = prod_neg & ~cy;

    // correction vector layout depends on whether lower-field bits ride along
    generate
        if (LB == 1) begin : g_carry_only
            assign corr = {{(UW - 1){fill}}, cy ^ prod_neg};
        end else begin : g_carry_and_msb
            assign corr = {{(UW - LB){fill}}, cy ^ prod_neg, lo_bits[LB-2:0]};
        end
    endgenerate

    // narrow upper add
    assign sum = hi_c + hi_d + corr;
endmodule

// File: rtl/ext_sum52.sv
// Split extended-precision signed adder, top level.
// The two-term form (three_in = 0) computes C + A*B and registers it on the
// sampling edge. The three-term form (three_in = 1) computes C + D + A*B through
// two pipeline registers and writes it two edges later. A due three-term result
// takes priority over a two-term operation sampled on the same edge.
// Assumes LOW_W > 2*MUL_W and RES_W > LOW_W + 1.
module ext_sum52
    import ext_sum52_pkg::*;
#(
    parameter int MUL_W = DEF_MUL_W,
    parameter int LOW_W = DEF_LOW_W,
    parameter int RES_W = DEF_RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MUL_W-1:0] op_a,
    input  logic [MUL_W-1:0] op_b,
    input  logic [RES_W-1:0] op_c,
    input  logic [RES_W-1:0] op_d,
    input  logic             three_in,
    output logic [RES_W-1:0] sum_q
);
    localparam int UP2_W = RES_W - LOW_W;      // upper field, two-term form
    localparam int UP3_W = RES_W - LOW_W + 1;  // upper field, three-term form
    localparam logic [LOW_W-1:0] LOW_ZERO = '0;
    localparam logic [UP2_W-1:0] UP2_ZERO = '0;

    // ---------------- two-term path, same-edge result ----------------
    logic [LOW_W-1:0] p2_ext;
    logic             p2_neg;
    logic [LOW_W-1:0] lo2_sum;
    logic             lo2_cy;
    logic [UP2_W-1:0] up2_sum;

    ext_sum52_mul #(.AW(MUL_W), .LW(LOW_W)) u_mul2 (
        .a(op_a), .b(op_b), .prod_ext(p2_ext), .prod_neg(p2_neg)
    );

    ext_sum52_low #(.LW(LOW_W)) u_low2 (
        .x(op_c[LOW_W-1:0]), .y(LOW_ZERO), .z(p2_ext),
        .sum(lo2_sum), .cout(lo2_cy)
    );

    ext_sum52_up #(.UW(UP2_W), .LB(1)) u_up2 (
        .hi_c(op_c[RES_W-1:LOW_W]), .hi_d(UP2_ZERO), .lo_bits(lo2_cy),
        .prod_neg(p2_neg), .sum(up2_sum)
    );

    // ---------------- three-term path, two pipeline stages ----------------
    logic [MUL_W-1:0] s1_a, s1_b;
    logic [RES_W-1:0] s1_c, s1_d;
    logic             s1_three;

    // stage 1: capture operands and form
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_a     <= '0;
            s1_b     <= '0;
            s1_c     <= '0;
            s1_d     <= '0;
            s1_three <= 1'b0;
        end else begin
            s1_a     <= op_a;
            s1_b     <= op_b;
            s1_c     <= op_c;
            s1_d     <= op_d;
            s1_three <= (three_in == FORM_THREE);
        end
    end

    logic [LOW_W-1:0] p3_ext;
    logic             p3_neg;
    logic [LOW_W-1:0] lo3_sum;
    logic             lo3_cy;

    ext_sum52_mul #(.AW(MUL_W), .LW(LOW_W)) u_mul3 (
        .a(s1_a), .b(s1_b), .prod_ext(p3_ext), .prod_neg(p3_neg)
    );

    ext_sum52_low #(.LW(LOW_W)) u_low3 (
        .x({1'b0, s1_c[LOW_W-2:0]}), .y({1'b0, s1_d[LOW_W-2:0]}), .z(p3_ext),
        .sum(lo3_sum), .cout(lo3_cy)
    );

    logic [LOW_W-1:0] s2_low;
    logic             s2_cy;
    logic             s2_neg;
    logic [UP3_W-1:0] s2_chi, s2_dhi;
    logic             s2_three;

    // stage 2: capture lower sum, carry, sign and the upper operand fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_low   <= '0;
            s2_cy    <= 1'b0;
            s2_neg   <= 1'b0;
            s2_chi   <= '0;
            s2_dhi   <= '0;
            s2_three <= 1'b0;
        end else begin
            s2_low   <= lo3_sum;
            s2_cy    <= lo3_cy;
            s2_neg   <= p3_neg;
            s2_chi   <= s1_c[RES_W-1:LOW_W-1];
            s2_dhi   <= s1_d[RES_W-1:LOW_W-1];
            s2_three <= s1_three;
        end
    end

    logic [UP3_W-1:0] up3_sum;

    ext_sum52_up #(.UW(UP3_W), .LB(2)) u_up3 (
        .hi_c(s2_chi), .hi_d(s2_dhi), .lo_bits({s2_cy, s2_low[LOW_W-1]}),
        .prod_neg(s2_neg), .sum(up3_sum)
    );

    // ---------------- result register ----------------
    // load a due three-term result first, else a two-term result, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (s2_three) begin
            sum_q <= {up3_sum, s2_low[LOW_W-2:0]};
        end else if (three_in == FORM_TWO) begin
            sum_q <= {up2_sum, lo2_sum};
        end
    end
endmodule

// File: rtl/ext_sum52_chk.sv
// Checker for ext_sum52. It keeps its own 52-bit reference sums and a two-deep
// history of the form input, and it relates these to sum_q on later edges.
// It is bound to every instance of the top module.
module ext_sum52_chk #(
    parameter int MUL_W = 18,
    parameter int RES_W = 52
) (
    input logic             clk,
    input logic             rst_n,
    input logic [MUL_W-1:0] op_a,
    input logic [MUL_W-1:0] op_b,
    input logic [RES_W-1:0] op_c,
    input logic [RES_W-1:0] op_d,
    input logic             three_in,
    input logic [RES_W-1:0] sum_q
);
    localparam int PW = 2 * MUL_W;

    logic signed [PW-1:0] prod;
    logic [RES_W-1:0]     prod_w;
    logic [RES_W-1:0]     ref2;
    logic [RES_W-1:0]     ref3;

    // plain full-width reference sums
    assign prod   = $signed(op_a) * $signed(op_b);
    assign prod_w = {{(RES_W - PW){prod[PW-1]}}, prod};
    assign ref2   = op_c + prod_w;
    assign ref3   = op_c + op_d + prod_w;

    logic             h1, h2;
    logic [RES_W-1:0] q1, q2;

    // form history and delayed three-term references
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h1 <= 1'b0;
            h2 <= 1'b0;
            q1 <= '0;
            q2 <= '0;
        end else begin
            h1 <= three_in;
            h2 <= h1;
            q1 <= ref3;
            q2 <= q1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (sum_q == '0));

    p_two_term_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!three_in && !h2) |=> (sum_q == $past(ref2)));

    p_three_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
        h2 |=> (sum_q == $past(q2)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (three_in && !h2) |=> $stable(sum_q));
endmodule

bind ext_sum52 ext_sum52_chk #(.MUL_W(MUL_W), .RES_W(RES_W)) i_ext_sum52_chk (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .op_d(op_d), .three_in(three_in), .sum_q(sum_q)
);

// File: tb/test_ext_sum52.sv
`timescale 1ns/1ps
// Self-checking bench for ext_sum52: directed corners plus seeded random mixes.
module test_ext_sum52;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] op_a = '0, op_b = '0;
    logic [51:0] op_c = '0, op_d = '0;
    logic        three_in = 1'b0;
    logic [51:0] sum_q;

    int checks = 0;
    int errors = 0;
    string phase = "R1 reset";

    // bench history: index 0 = op sampled on the last edge
    logic        hist_three [3];
    logic [51:0] hist_ref   [3];
    logic [51:0] exp_q = '0;

    ext_sum52 i_ext_sum52 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .op_d(op_d), .three_in(three_in), .sum_q(sum_q)
    );

    always #5 clk = ~clk;

    function automatic logic [51:0] ref_sum(input logic [17:0] a, input logic [17:0] b,
                                            input logic [51:0] c, input logic [51:0] d,
                                            input logic three);
        logic signed [35:0] pr;
        logic [51:0]        pw;
        pr = $signed(a) * $signed(b);
        pw = {{16{pr[35]}}, pr};
        return c + pw + (three ? d : 52'd0);
    endfunction

    task automatic check(input logic [51:0] act, input logic [51:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s]: sum_q=%h expected=%h", req, phase, act, exp);
        end
    endtask

    // drive one operation at a falling edge, let one rising edge pass, check
    task automatic step(input logic [17:0] a, input logic [17:0] b, input logic [51:0] c,
                        input logic [51:0] d, input logic m, input logic rl);
        string req;
        op_a = a; op_b = b; op_c = c; op_d = d; three_in = m; rst_n = rl;
        @(posedge clk);
        @(negedge clk);
        hist_three[2] = hist_three[1]; hist_ref[2] = hist_ref[1];
        hist_three[1] = hist_three[0]; hist_ref[1] = hist_ref[0];
        hist_three[0] = m;             hist_ref[0] = ref_sum(a, b, c, d, m);
        if (!rl) begin
            for (int i = 0; i < 3; i++) hist_three[i] = 1'b0;
            exp_q = '0;
            req = "R1";
        end else if (hist_three[2]) begin
            exp_q = hist_ref[2];
            req = m ? "R3" : "R5";
        end else if (!m) begin
            exp_q = hist_ref[0];
            req = "R2";
        end else begin
            req = "R6";
        end
        check(sum_q, exp_q, req);
    endtask

    function automatic logic [51:0] pick52(input int sel);
        logic [63:0] t;
        case (sel)
            0: return 52'h7_FFFF_FFFF_FFFF;
            1: return 52'h8_0000_0000_0000;
            2: return 52'hF_FFFF_FFFF_FFFF;
            3: return 52'h0_0FFF_FFFF_FFFF;
            4: return 52'h0_07FF_FFFF_FFFF;
            5: return 52'hF_F000_0000_0000;
            default: begin
                t = {$urandom(), $urandom()};
                return t[51:0];
            end
        endcase
    endfunction

    function automatic logic [17:0] pick18(input int sel);
        case (sel)
            0: return 18'h20000;
            1: return 18'h1FFFF;
            2: return 18'h3FFFF;
            3: return 18'h00001;
            4: return 18'h00000;
            default: return 18'($urandom());
        endcase
    endfunction

    // watchdog
    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 3; i++) begin
            hist_three[i] = 1'b0;
            hist_ref[i] = '0;
        end
        @(negedge clk);
        // R1: reset state, and a three-term op killed by reset
        step(18'h00005, 18'h00007, 52'd100, 52'd200, 1'b0, 1'b0);
        step(18'h00005, 18'h00007, 52'd100, 52'd200, 1'b0, 1'b0);
        step(18'h00003, 18'h00003, 52'd1, 52'd2, 1'b1, 1'b1);
        step(18'h00000, 18'h00000, 52'd0, 52'd0, 1'b1, 1'b0);
        step(18'h00000, 18'h00000, 52'd0, 52'd0, 1'b1, 1'b0);
        step(18'h00000, 18'h00000, 52'd0, 52'd0, 1'b1, 1'b1);
        step(18'h00000, 18'h00000, 52'd0, 52'd0, 1'b1, 1'b1);
        step(18'h00000, 18'h00000, 52'd0, 52'd0, 1'b1, 1'b1);

        // R7: two-term results with different D values
        phase = "R7 D ignored";
        step(18'h00011, 18'h3FFF0, 52'h1234_5678_9ABC, 52'hF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
        step(18'h00011, 18'h3FFF0, 52'h1234_5678_9ABC, 52'h0, 1'b0, 1'b1);
        step(18'h00011, 18'h3FFF0, 52'h1234_5678_9ABC, 52'h8_0000_0000_0000, 1'b0, 1'b1);

        // R4: boundary corners in both forms
        phase = "R4 corners";
        for (int m = 0; m < 2; m++) begin
            for (int pa = 0; pa < 5; pa++) begin
                for (int sc = 0; sc < 6; sc++) begin
                    step(pick18(pa), pick18((pa + 1) % 5), pick52(sc),
                         pick52((sc + 2) % 6), m[0], 1'b1);
                end
            end
            // drain the three-term pipeline
            step(18'h0, 18'h0, 52'h0, 52'h0, m[0], 1'b1);
            step(18'h0, 18'h0, 52'h0, 52'h0, m[0], 1'b1);
        end
        // largest positive product with C at the top of range, then wrap
        step(18'h20000, 18'h20000, 52'h7_FFFF_FFFF_FFFF, 52'h0, 1'b0, 1'b1);
        step(18'h20000, 18'h20000, 52'h7_FFFF_FFFF_FFFF, 52'h7_FFFF_FFFF_FFFF, 1'b1, 1'b1);
        step(18'h20000, 18'h1FFFF, 52'h8_0000_0000_0000, 52'h8_0000_0000_0000, 1'b1, 1'b1);
        step(18'h0, 18'h0, 52'h0, 52'h0, 1'b1, 1'b1);
        step(18'h0, 18'h0, 52'h0, 52'h0, 1'b1, 1'b1);

        // R5/R6: directed mode switches, three-term then two-term back to back
        phase = "R5 R6 switch";
        step(18'h00002, 18'h00003, 52'd10, 52'd20, 1'b1, 1'b1);
        step(18'h00004, 18'h00005, 52'd30, 52'd40, 1'b0, 1'b1);
        step(18'h00006, 18'h00007, 52'd50, 52'd60, 1'b0, 1'b1);
        step(18'h00008, 18'h00009, 52'd70, 52'd80, 1'b0, 1'b1);

        // R8: seeded random mix of forms and operands
        phase = "R8 random mix";
        for (int n = 0; n < 3000; n++) begin
            step(pick18(int'($urandom_range(0, 9))), pick18(int'($urandom_range(0, 9))),
                 pick52(int'($urandom_range(0, 11))), pick52(int'($urandom_range(0, 11))),
                 1'($urandom_range(0, 1)), 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule